// File: doc/BRIEF.md
# Microprocessor Slave Data Port

This block lets an external microprocessor treat an 8-bit register inside a controller core as a plain latch on its own data bus. The external master uses three active-low strobes: chip select, read and write. All three are asynchronous to the core. They pass through multi-flop synchronizers and are then edge-detected in the core clock domain. A write transaction deposits the bus value into an inbound latch. A read transaction drives the contents of an outbound latch onto the bus, with the output enable raised for exactly as long as the read lasts.

Firmware reaches the port through single-cycle strobes. It loads outbound data, reads inbound data and clears the sticky interrupt and overflow flags. Four status outputs report the port state: inbound full, outbound full, inbound overflow and interrupt. Slave operation needs a mode-enable input to be set. While that input is low, the strobes are ignored. If the input drops during a transaction, the transaction is abandoned and no end event is raised.

Top module: `upbus_slave_port`

## Requirements
- R1: After reset, in_full, out_full, in_ovf, irq and bus_oe are all 0.
- R2: An external write begins when the synchronized chip select and write are both low. It ends when either of them is seen high again. At that end the bus value is stored into fw_in_data, and in_full and irq are set. Neither flag changes while the write is still in progress.
- R3: If a write ends while in_full is already 1 and no firmware inbound read happens in that cycle, in_ovf is set. The inbound latch still takes the new value.
- R4: A pulse on fw_in_re clears in_full. If the pulse falls in the same cycle as a write end, in_full stays 1 and in_ovf is not set.
- R5: An external read begins when the synchronized chip select and read are both low. From then on bus_oe is 1, bus_out carries the outbound latch, and out_full is cleared.
- R6: A read ends when chip select or read is seen high. bus_oe then returns to 0 and irq is set.
- R7: A pulse on fw_out_we loads the outbound latch and sets out_full. If a read is already in progress, the new value appears on bus_out at once but out_full stays 0.
- R8: A pulse on fw_flag_clr clears irq and in_ovf. A new set event in the same cycle takes priority over the clear.
- R9: While slave_en is 0, the strobes set no flag and do not raise bus_oe. If slave_en is dropped during a write, the write is discarded with no flag change.
- R10: A write strobe or read strobe with chip select high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | Enables slave operation |
| cs_n | input | 1 | External chip select, active low, asynchronous |
| rd_n | input | 1 | External read strobe, active low, asynchronous |
| wr_n | input | 1 | External write strobe, active low, asynchronous |
| bus_in | input | DATA_W | Data bus as seen from the pad input |
| bus_out | output | DATA_W | Data driven toward the pad |
| bus_oe | output | 1 | Pad output enable; 0 means high impedance |
| fw_out_we | input | 1 | Firmware load strobe for the outbound latch |
| fw_out_data | input | DATA_W | Firmware outbound data |
| fw_in_re | input | 1 | Firmware read strobe for the inbound latch |
| fw_in_data | output | DATA_W | Inbound latch contents |
| fw_flag_clr | input | 1 | Clears irq and in_ovf |
| in_full | output | 1 | Inbound latch holds unread data |
| out_full | output | 1 | Outbound latch not yet read externally |
| in_ovf | output | 1 | Inbound data overwritten before it was read |
| irq | output | 1 | Sticky transaction-end interrupt |

## Verification
Two events can land on the same clock edge: the synchronized end of an external write and a firmware read of the inbound latch. The bench counts the synchronizer depth and releases the write strobe so that the detected write end falls on exactly the edge where the fw_in_re pulse is sampled. The outcome is correct if in_full stays set, in_ovf stays clear and fw_in_data holds the newly written byte. A second case drives an outbound firmware load while a read is in progress. That case is judged by bus_out taking the new value with out_full still at 0.

// File: rtl/upbus_pkg.sv
package upbus_pkg;

   // synchronized strobe levels, 1 = idle (high)
   typedef struct packed {
      logic cs;
      logic rd;
      logic wr;
   } strobe_t;

   localparam int STROBE_N = 3;

   // single-cycle transaction events in the core domain
   typedef struct packed {
      logic wr_start;
      logic wr_end;
      logic rd_start;
      logic rd_end;
      logic rd_sel;
   } xact_ev_t;

endpackage

// File: rtl/upbus_sync.sv
module upbus_sync #(
   parameter int   WIDTH   = 3,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("upbus_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("upbus_sync: WIDTH must be positive");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d[i]};
      end
      assign q[i] = chain[STAGES-1];
   end

endmodule

// File: rtl/upbus_xact.sv
module upbus_xact
   import upbus_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     slave_en,
   input  strobe_t  s,
   output xact_ev_t ev,
   output logic     rd_act
);

   logic wr_sel, rd_sel, wr_act;

   assign wr_sel = slave_en & ~s.cs & ~s.wr;
   assign rd_sel = slave_en & ~s.cs & ~s.rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act <= 1'b0;
         rd_act <= 1'b0;
      end else begin
         wr_act <= wr_sel;
         rd_act <= rd_sel;
      end
   end

   // an end needs the enable still set: dropping slave_en aborts silently
   assign ev.wr_start = wr_sel & ~wr_act;
   assign ev.wr_end   = wr_act & ~wr_sel & slave_en;
   assign ev.rd_start = rd_sel & ~rd_act;
   assign ev.rd_end   = rd_act & ~rd_sel & slave_en;
   assign ev.rd_sel   = rd_sel;

   // R9: with the mode disabled nothing starts
   p_no_start_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_en |-> !ev.wr_start && !ev.rd_start);
   // R6: a read end always drops the driver on the next edge
   p_oe_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev.rd_end |=> !rd_act);
   // R2: a write cannot start and end in one cycle
   p_wr_events_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev.wr_start && ev.wr_end));

endmodule

// File: rtl/upbus_core.sv
module upbus_core
   import upbus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xact_ev_t          ev,
   input  logic [DATA_W-1:0] bus_in,
   input  logic              fw_out_we,
   input  logic [DATA_W-1:0] fw_out_data,
   input  logic              fw_in_re,
   input  logic              fw_flag_clr,
   output logic [DATA_W-1:0] in_latch,
   output logic [DATA_W-1:0] out_latch,
   output logic              in_full,
   output logic              out_full,
   output logic              in_ovf,
   output logic              irq
);

   if (DATA_W < 1) begin : g_bad_width
      $error("upbus_core: DATA_W must be positive");
   end

   logic in_full_d, out_full_d, in_ovf_d, irq_d, ovf_set;

   assign ovf_set = ev.wr_end & in_full & ~fw_in_re;

   always_comb begin
      in_full_d = in_full;
      if (ev.wr_end)      in_full_d = 1'b1;
      else if (fw_in_re)  in_full_d = 1'b0;

      out_full_d = out_full;
      if (ev.rd_start)                  out_full_d = 1'b0;
      else if (fw_out_we && !ev.rd_sel) out_full_d = 1'b1;

      in_ovf_d = in_ovf;
      if (ovf_set)          in_ovf_d = 1'b1;
      else if (fw_flag_clr) in_ovf_d = 1'b0;

      irq_d = irq;
      if (ev.wr_end || ev.rd_end) irq_d = 1'b1;
      else if (fw_flag_clr)       irq_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_latch  <= '0;
         out_latch <= '0;
         in_full   <= 1'b0;
         out_full  <= 1'b0;
         in_ovf    <= 1'b0;
         irq       <= 1'b0;
      end else begin
         if (ev.wr_end)  in_latch  <= bus_in;
         if (fw_out_we)  out_latch <= fw_out_data;
         in_full  <= in_full_d;
         out_full <= out_full_d;
         in_ovf   <= in_ovf_d;
         irq      <= irq_d;
      end
   end

   p_wr_end_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev.wr_end |=> in_full && irq);
   p_wr_end_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev.wr_end |=> in_latch == $past(bus_in));
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.wr_end && in_full && !fw_in_re) |=> in_ovf);
   p_in_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_in_re && !ev.wr_end) |=> !in_full);
   p_race_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_in_re && ev.wr_end && !in_ovf) |=> in_full && !in_ovf);
   p_out_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev.rd_start |=> !out_full);
   p_rd_end_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev.rd_end |=> irq);
   p_out_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_out_we && !ev.rd_sel) |=> out_full);
   p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.rd_sel && !ev.rd_start) |=> !out_full);
   p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_flag_clr && !ev.wr_end && !ev.rd_end) |=> !irq && !in_ovf);

endmodule

// File: rtl/upbus_slave_port.sv
module upbus_slave_port
   import upbus_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slave_en,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic              fw_out_we,
   input  logic [DATA_W-1:0] fw_out_data,
   input  logic              fw_in_re,
   output logic [DATA_W-1:0] fw_in_data,
   input  logic              fw_flag_clr,
   output logic              in_full,
   output logic              out_full,
   output logic              in_ovf,
   output logic              irq
);

   strobe_t  raw_s, sync_s;
   xact_ev_t ev;
   logic     rd_act;

   assign raw_s = '{cs: cs_n, rd: rd_n, wr: wr_n};

   upbus_sync #(
      .WIDTH   (STROBE_N),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_s),
      .q     (sync_s)
   );

   upbus_xact u_xact (
      .clk      (clk),
      .rst_n    (rst_n),
      .slave_en (slave_en),
      .s        (sync_s),
      .ev       (ev),
      .rd_act   (rd_act)
   );

   upbus_core #(.DATA_W(DATA_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev          (ev),
      .bus_in      (bus_in),
      .fw_out_we   (fw_out_we),
      .fw_out_data (fw_out_data),
      .fw_in_re    (fw_in_re),
      .fw_flag_clr (fw_flag_clr),
      .in_latch    (fw_in_data),
      .out_latch   (bus_out),
      .in_full     (in_full),
      .out_full    (out_full),
      .in_ovf      (in_ovf),
      .irq         (irq)
   );

   assign bus_oe = rd_act;

   // R10: chip select held high keeps the bus released
   p_cs_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_s.cs && $past(sync_s.cs)) |-> !bus_oe);

endmodule

// File: tb/upbus_slave_port_tb.sv
`timescale 1ns/1ps
module upbus_slave_port_tb;

   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slave_en = 1'b0;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [W-1:0] bus_in = '0;
   logic [W-1:0] bus_out;
   logic bus_oe;
   logic fw_out_we = 1'b0;
   logic [W-1:0] fw_out_data = '0;
   logic fw_in_re = 1'b0;
   logic [W-1:0] fw_in_data;
   logic fw_flag_clr = 1'b0;
   logic in_full, out_full, in_ovf, irq;

   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   upbus_slave_port #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .slave_en(slave_en),
      .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .fw_out_we(fw_out_we), .fw_out_data(fw_out_data),
      .fw_in_re(fw_in_re), .fw_in_data(fw_in_data),
      .fw_flag_clr(fw_flag_clr),
      .in_full(in_full), .out_full(out_full), .in_ovf(in_ovf), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fw_write(input logic [W-1:0] d);
      @(negedge clk); fw_out_we = 1'b1; fw_out_data = d;
      @(negedge clk); fw_out_we = 1'b0;
   endtask

   task automatic fw_read();
      @(negedge clk); fw_in_re = 1'b1;
      @(negedge clk); fw_in_re = 1'b0;
   endtask

   task automatic fw_clear();
      @(negedge clk); fw_flag_clr = 1'b1;
      @(negedge clk); fw_flag_clr = 1'b0;
   endtask

   // full external write; cs_first picks which strobe is released first
   task automatic ext_write(input logic [W-1:0] d, input bit cs_first);
      @(negedge clk); bus_in = d; wr_n = 1'b0;
      cycles(int'($urandom_range(0, 2)));
      cs_n = 1'b0;
      cycles(int'($urandom_range(4, 9)));
      if (cs_first) cs_n = 1'b1; else wr_n = 1'b1;
      cycles(int'($urandom_range(4, 6)));
      cs_n = 1'b1; wr_n = 1'b1;
      cycles(1);
   endtask

   task automatic t_reset();
      chk("R1 in_full", in_full, 0);
      chk("R1 out_full", out_full, 0);
      chk("R1 in_ovf", in_ovf, 0);
      chk("R1 irq", irq, 0);
      chk("R1 bus_oe", bus_oe, 0);
   endtask

   task automatic t_write();
      @(negedge clk); bus_in = 8'hA5; cs_n = 1'b0; wr_n = 1'b0;
      cycles(6);
      chk("R2 in_full mid-write", in_full, 0);
      chk("R2 irq mid-write", irq, 0);
      wr_n = 1'b1;
      cycles(5);
      cs_n = 1'b1;
      chk("R2 in_full", in_full, 1);
      chk("R2 irq", irq, 1);
      chk("R2 data", fw_in_data, 8'hA5);
      chk("R2 in_ovf", in_ovf, 0);
   endtask

   task automatic t_overflow();
      ext_write(8'h3C, 1'b1);
      chk("R3 in_ovf", in_ovf, 1);
      chk("R3 latch updated", fw_in_data, 8'h3C);
      fw_clear();
      chk("R8 irq cleared", irq, 0);
      chk("R8 in_ovf cleared", in_ovf, 0);
      fw_read();
      chk("R4 in_full cleared", in_full, 0);
   endtask

   task automatic t_race();
      ext_write(8'h11, 1'b0);
      chk("R4 precondition in_full", in_full, 1);
      @(negedge clk); bus_in = 8'h77; cs_n = 1'b0; wr_n = 1'b0;
      cycles(6);
      wr_n = 1'b1;
      // release seen after two sync edges; end is sampled on the third edge
      @(posedge clk); @(posedge clk);
      @(negedge clk); fw_in_re = 1'b1;
      @(negedge clk); fw_in_re = 1'b0;
      cs_n = 1'b1;
      chk("R4 race in_full", in_full, 1);
      chk("R4 race in_ovf", in_ovf, 0);
      chk("R4 race data", fw_in_data, 8'h77);
      fw_read();
      fw_clear();
   endtask

   task automatic t_read(input bit via_cs);
      fw_write(8'hC3);
      chk("R7 out_full set", out_full, 1);
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
      cycles(int'($urandom_range(4, 8)));
      chk("R5 bus_oe", bus_oe, 1);
      chk("R5 bus_out", bus_out, 8'hC3);
      chk("R5 out_full cleared", out_full, 0);
      fw_write(8'h5A);
      chk("R7 new data driven", bus_out, 8'h5A);
      chk("R7 out_full held low", out_full, 0);
      if (via_cs) cs_n = 1'b1; else rd_n = 1'b1;
      cycles(4);
      cs_n = 1'b1; rd_n = 1'b1;
      chk("R6 bus_oe released", bus_oe, 0);
      chk("R6 irq", irq, 1);
      fw_clear();
   endtask

   task automatic t_disabled();
      slave_en = 1'b0;
      ext_write(8'hEE, 1'b0);
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
      cycles(5);
      chk("R9 bus_oe disabled", bus_oe, 0);
      cs_n = 1'b1; rd_n = 1'b1;
      cycles(4);
      chk("R9 in_full disabled", in_full, 0);
      chk("R9 irq disabled", irq, 0);
      chk("R9 data unchanged", fw_in_data, 8'h77);
      slave_en = 1'b1;
      @(negedge clk); bus_in = 8'h99; cs_n = 1'b0; wr_n = 1'b0;
      cycles(6);
      slave_en = 1'b0;
      cycles(2);
      cs_n = 1'b1; wr_n = 1'b1;
      cycles(4);
      slave_en = 1'b1;
      cycles(4);
      chk("R9 abort in_full", in_full, 0);
      chk("R9 abort irq", irq, 0);
   endtask

   task automatic t_no_cs();
      @(negedge clk); bus_in = 8'h42; wr_n = 1'b0;
      cycles(6);
      wr_n = 1'b1;
      cycles(4);
      chk("R10 write without cs", in_full, 0);
      rd_n = 1'b0;
      cycles(5);
      chk("R10 read without cs", bus_oe, 0);
      rd_n = 1'b1;
      cycles(4);
      chk("R10 irq", irq, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      cycles(3);
      t_reset();
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      slave_en = 1'b1;
      cycles(2);
      t_write();
      t_overflow();
      t_race();
      t_read(1'b1);
      t_read(1'b0);
      t_disabled();
      t_no_cs();
      for (int i = 0; i < 6; i++) begin
         logic [W-1:0] d;
         d = W'($urandom);
         ext_write(d, i[0]);
         chk("R2 random data", fw_in_data, d);
         chk("R2 random in_full", in_full, 1);
         fw_read();
         chk("R4 random clear", in_full, 0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule